// File: doc/BRIEF.md
# Multi-Queue Word FIFO Bank

This block holds sixty-four independent queues of 32-bit words behind a small synchronous register port. Software or a neighbouring engine pushes a word into a queue by writing the first word of that queue's four-word access window, and pulls the oldest word out by reading the same location. Each queue has its own configured length and two watermark codes. The codes decide when the queue reports that it is nearly empty or nearly full. Storage is a private array per queue, sized by a parameter.

The block packs its flags into status words that can be read back. The lower thirty-two queues report four flags each (empty, nearly empty, nearly full, full) and carry sticky underflow and overflow bits, which clear when they are read. The upper thirty-two queues report only a nearly-empty bit and a full bit, each gathered into a single word.

The port has separate read and write addresses, so one queue can be pushed and popped in the same cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `qm_bank`

## Requirements
- R1: After reset every queue is empty, its length is MAX_DEPTH (8) and both watermark codes are 0, and `rd_data` is 0.
- R2: A write to word address 4*q pushes `wr_data` into queue q, and a read of 4*q pops the oldest word in FIFO order, with the value on `rd_data` one cycle after `rd_en`. Writes to offsets 1 to 3 of a window are ignored, and reads of those offsets return 0 without popping.
- R3: Word address 0x180+q is queue q's setup register: bits [7:0] hold the length, bits [10:8] the nearly-empty code and bits [14:12] the nearly-full code. Writing it empties the queue. A length of 0 or a length above MAX_DEPTH is stored as MAX_DEPTH, and a read returns the stored fields in the same positions.
- R4: A watermark code c decodes to 0, 1 or 2 entries for c = 0, 1, 2, and to 2^(c-1) entries for c = 3 to 7. Nearly-empty holds when occupancy <= the decoded nearly-empty value, and nearly-full holds when length minus occupancy <= the decoded nearly-full value.
- R5: For queue q < 32, the status word at 0x100 + q/8 holds a nibble at bit 4*(q mod 8): bit0 empty, bit1 nearly empty, bit2 nearly full, bit3 full.
- R6: For queue q >= 32, bit q-32 of word 0x106 is its nearly-empty flag and bit q-32 of word 0x107 is its full flag.
- R7: A pop from an empty queue returns 0 and leaves the queue unchanged. For q < 32 it also sets the underflow bit, which is bit 2*(q mod 16) of word 0x104 + q/16.
- R8: A push to a full queue (with no pop on the same queue that cycle) is dropped and the queue's contents are kept. For q < 32 it also sets the overflow bit, which is bit 2*(q mod 16)+1 of the same word.
- R9: Reading a sticky word returns its bits and clears the bits of its sixteen queues. An event in the same cycle as the read is kept, so it shows on the next read.
- R10: A push and a pop on the same queue in one cycle leave the occupancy unchanged, even when the queue is full. The pop returns the oldest word, and the flags reflect the result from the next cycle.
- R11: Reads of unmapped addresses return 0, and writes to unmapped addresses, status words or sticky words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Word address of the read |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |

## Verification
The assertions assume that each strobe carries one well-formed access per cycle. They also assume that a setup write is never issued to a queue that is being pushed or popped in the same cycle, since a setup write would override that traffic. The directed stimulus obeys both rules: it configures each queue before touching its window, and it pairs a read and a write in the same cycle only in the scenarios that call for it, namely push with pop on one queue, and overflow with a sticky read.

// File: rtl/qm_pkg.sv
`timescale 1ns/1ps
package qm_pkg;
  parameter int NQ        = 64;
  parameter int HALF      = NQ / 2;
  parameter int DW        = 32;
  parameter int AW        = 9;
  parameter int MAX_DEPTH = 8;
  parameter int CW        = $clog2(MAX_DEPTH + 1);
  parameter int TW        = 8;

  localparam logic [AW-1:0] A_STAT4  = 9'h100;
  localparam logic [AW-1:0] A_STICKY = 9'h104;
  localparam logic [AW-1:0] A_NE_HI  = 9'h106;
  localparam logic [AW-1:0] A_FU_HI  = 9'h107;

  function automatic logic [TW-1:0] wm_decode(input logic [2:0] code);
    logic [TW-1:0] v;
    case (code)
      3'd0:    v = '0;
      3'd1:    v = TW'(1);
      3'd2:    v = TW'(2);
      default: v = TW'(1) << (code - 3'd1);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/qm_lane.sv
`timescale 1ns/1ps
module qm_lane
  import qm_pkg::*;
#(
  parameter int DEPTH = MAX_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_len,
  input  logic [2:0]    cfg_ne,
  input  logic [2:0]    cfg_nf,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          nempty,
  output logic          nfull,
  output logic          full,
  output logic          pop_ok,
  output logic          uf_ev,
  output logic          of_ev,
  output logic [CW-1:0] len_o,
  output logic [2:0]    ne_o,
  output logic [2:0]    nf_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] count_q, count_d;
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] len_q, len_d;
  logic [2:0]    ne_q, ne_d, nf_q, nf_d;
  logic          push_ok;
  logic [PW-1:0] last_idx;
  logic [TW-1:0] occ_w, free_w;

  assign last_idx = PW'(len_q - CW'(1));
  assign occ_w    = TW'(count_q);
  assign free_w   = TW'(len_q - count_q);

  always_comb begin
    empty   = (count_q == '0);
    full    = (count_q == len_q);
    nempty  = (occ_w  <= wm_decode(ne_q));
    nfull   = (free_w <= wm_decode(nf_q));
    pop_ok  = pop & ~empty & ~cfg_we;
    push_ok = push & ~cfg_we & (~full | pop_ok);
    uf_ev   = pop & empty & ~cfg_we;
    of_ev   = push & ~cfg_we & full & ~pop_ok;
  end

  always_comb begin
    count_d = count_q;
    wp_d    = wp_q;
    rp_d    = rp_q;
    len_d   = len_q;
    ne_d    = ne_q;
    nf_d    = nf_q;
    if (cfg_we) begin
      count_d = '0;
      wp_d    = '0;
      rp_d    = '0;
      len_d   = cfg_len;
      ne_d    = cfg_ne;
      nf_d    = cfg_nf;
    end else begin
      if (push_ok) wp_d = (wp_q == last_idx) ? '0 : wp_q + PW'(1);
      if (pop_ok)  rp_d = (rp_q == last_idx) ? '0 : rp_q + PW'(1);
      if (push_ok && !pop_ok)      count_d = count_q + CW'(1);
      else if (pop_ok && !push_ok) count_d = count_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wp_q    <= '0;
      rp_q    <= '0;
      len_q   <= CW'(DEPTH);
      ne_q    <= '0;
      nf_q    <= '0;
    end else begin
      count_q <= count_d;
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      len_q   <= len_d;
      ne_q    <= ne_d;
      nf_q    <= nf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign len_o = len_q;
  assign ne_o  = ne_q;
  assign nf_o  = nf_q;
endmodule

// File: rtl/qm_status_pack.sv
`timescale 1ns/1ps
module qm_status_pack
  import qm_pkg::*;
(
  input  logic [NQ-1:0]   empty_v,
  input  logic [NQ-1:0]   nempty_v,
  input  logic [NQ-1:0]   nfull_v,
  input  logic [NQ-1:0]   full_v,
  input  logic [HALF-1:0] uf_v,
  input  logic [HALF-1:0] of_v,
  output logic [DW-1:0]   stat4_w [HALF/8],
  output logic [DW-1:0]   sticky_w [HALF/16],
  output logic [DW-1:0]   ne_hi,
  output logic [DW-1:0]   fu_hi
);
  for (genvar w = 0; w < HALF/8; w++) begin : g_s4
    for (genvar k = 0; k < 8; k++) begin : g_q
      assign stat4_w[w][4*k +: 4] = {full_v[8*w+k], nfull_v[8*w+k],
                                     nempty_v[8*w+k], empty_v[8*w+k]};
    end
  end

  for (genvar w = 0; w < HALF/16; w++) begin : g_s2
    for (genvar k = 0; k < 16; k++) begin : g_q
      assign sticky_w[w][2*k +: 2] = {of_v[16*w+k], uf_v[16*w+k]};
    end
  end

  assign ne_hi = DW'(nempty_v[NQ-1:HALF]);
  assign fu_hi = DW'(full_v[NQ-1:HALF]);
endmodule

// File: rtl/qm_bank.sv
`timescale 1ns/1ps
module qm_bank
  import qm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int QW = $clog2(NQ);

  logic [NQ-1:0] empty_v, nempty_v, nfull_v, full_v;
  logic [NQ-1:0] pop_ok_v, uf_ev_v, of_ev_v;
  logic [NQ-1:0] push_v, pop_v, cfg_v;
  logic [DW-1:0] head_a [NQ];
  logic [CW-1:0] len_a  [NQ];
  logic [2:0]    ne_a   [NQ];
  logic [2:0]    nf_a   [NQ];

  logic          wr_win, rd_win, wr_cfg, rd_cfg;
  logic [QW-1:0] wq, rq;
  logic [CW-1:0] cfg_len;

  logic [HALF-1:0] uf_q, uf_d, of_q, of_d, clr_m;
  logic [DW-1:0]   stat4_w [HALF/8];
  logic [DW-1:0]   sticky_w [HALF/16];
  logic [DW-1:0]   ne_hi, fu_hi;
  logic [DW-1:0]   rd_d, rd_q;

  // address decode
  always_comb begin
    wr_win = wr_en & ~wr_addr[8] & (wr_addr[1:0] == 2'b00);
    rd_win = rd_en & ~rd_addr[8] & (rd_addr[1:0] == 2'b00);
    wr_cfg = wr_en & (wr_addr[8:6] == 3'b110);
    rd_cfg = (rd_addr[8:6] == 3'b110);
    wq     = wr_cfg ? wr_addr[QW-1:0] : wr_addr[QW+1:2];
    rq     = rd_addr[QW+1:2];
    push_v = wr_win ? (NQ'(1) << wq) : '0;
    pop_v  = rd_win ? (NQ'(1) << rq) : '0;
    cfg_v  = wr_cfg ? (NQ'(1) << wq) : '0;
    if ((wr_data[7:0] == 8'd0) || (wr_data[7:0] > 8'(MAX_DEPTH)))
      cfg_len = CW'(MAX_DEPTH);
    else
      cfg_len = wr_data[CW-1:0];
  end

  for (genvar g = 0; g < NQ; g++) begin : g_lane
    qm_lane #(.DEPTH(MAX_DEPTH)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_v[g]),
      .cfg_len   (cfg_len),
      .cfg_ne    (wr_data[10:8]),
      .cfg_nf    (wr_data[14:12]),
      .push      (push_v[g]),
      .pop       (pop_v[g]),
      .push_data (wr_data),
      .head      (head_a[g]),
      .empty     (empty_v[g]),
      .nempty    (nempty_v[g]),
      .nfull     (nfull_v[g]),
      .full      (full_v[g]),
      .pop_ok    (pop_ok_v[g]),
      .uf_ev     (uf_ev_v[g]),
      .of_ev     (of_ev_v[g]),
      .len_o     (len_a[g]),
      .ne_o      (ne_a[g]),
      .nf_o      (nf_a[g])
    );
  end

  // sticky error bits: a new event beats a clear in the same cycle
  always_comb begin
    clr_m = '0;
    if (rd_en) begin
      for (int w = 0; w < HALF/16; w++) begin
        if (rd_addr == A_STICKY + AW'(w)) clr_m[16*w +: 16] = '1;
      end
    end
    uf_d = (uf_q & ~clr_m) | uf_ev_v[HALF-1:0];
    of_d = (of_q & ~clr_m) | of_ev_v[HALF-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q <= '0;
      of_q <= '0;
    end else begin
      uf_q <= uf_d;
      of_q <= of_d;
    end
  end

  qm_status_pack u_pack (
    .empty_v  (empty_v),
    .nempty_v (nempty_v),
    .nfull_v  (nfull_v),
    .full_v   (full_v),
    .uf_v     (uf_q),
    .of_v     (of_q),
    .stat4_w  (stat4_w),
    .sticky_w (sticky_w),
    .ne_hi    (ne_hi),
    .fu_hi    (fu_hi)
  );

  // read mux
  always_comb begin
    rd_d = '0;
    if (!rd_addr[8]) begin
      if (pop_ok_v[rq]) rd_d = head_a[rq];
    end else if (rd_cfg) begin
      rd_d[7:0]   = 8'(len_a[rd_addr[QW-1:0]]);
      rd_d[10:8]  = ne_a[rd_addr[QW-1:0]];
      rd_d[14:12] = nf_a[rd_addr[QW-1:0]];
    end else begin
      for (int w = 0; w < HALF/8; w++)
        if (rd_addr == A_STAT4 + AW'(w)) rd_d = stat4_w[w];
      for (int w = 0; w < HALF/16; w++)
        if (rd_addr == A_STICKY + AW'(w)) rd_d = sticky_w[w];
      if (rd_addr == A_NE_HI) rd_d = ne_hi;
      if (rd_addr == A_FU_HI) rd_d = fu_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/qm_bank_chk.sv
`timescale 1ns/1ps
module qm_bank_chk
  import qm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic            rd_en,
  input logic [AW-1:0]   rd_addr,
  input logic [DW-1:0]   rd_data,
  input logic [NQ-1:0]   empty_v,
  input logic [NQ-1:0]   full_v,
  input logic [NQ-1:0]   uf_ev_v,
  input logic [HALF-1:0] uf_q
);
  logic rwin, wwin, same_q;
  assign rwin   = rd_en && !rd_addr[8] && (rd_addr[1:0] == 2'b00);
  assign wwin   = wr_en && !wr_addr[8] && (wr_addr[1:0] == 2'b00);
  assign same_q = rwin && (rd_addr[7:2] == wr_addr[7:2]);

  // R7: pop of an empty queue yields zero
  p_pop_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rwin && empty_v[rd_addr[7:2]]) |=> (rd_data == '0));

  // R7: the underflow is recorded for a lower queue
  p_underflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rwin && !rd_addr[7] && empty_v[rd_addr[7:2]]) |=> uf_q[$past(rd_addr[6:2])]);

  // R3: a setup write leaves the queue empty
  p_cfg_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[8:6] == 3'b110) |=> empty_v[$past(wr_addr[5:0])]);

  // R8: a dropped push leaves a full queue full
  p_overflow_keeps_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wwin && full_v[wr_addr[7:2]] && !same_q) |=> full_v[$past(wr_addr[7:2])]);

  // R9: reading the first sticky word clears its underflow bits
  p_sticky_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_STICKY && uf_ev_v[15:0] == '0) |=> (uf_q[15:0] == '0));
endmodule

bind qm_bank qm_bank_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .empty_v (empty_v),
  .full_v  (full_v),
  .uf_ev_v (uf_ev_v),
  .uf_q    (uf_q)
);

// File: tb/qm_bank_bench.sv
`timescale 1ns/1ps
module qm_bank_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [8:0]  rd_addr;
  logic [31:0] rd_data;
  int n_run;
  int n_fail;

  qm_bank u_qm_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_both(input logic [8:0] wa, input logic [31:0] wd,
                         input logic [8:0] ra, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = wa; wr_data = wd;
    rd_en = 1'b1; rd_addr = ra;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [8:0] win(input int q);
    return 9'(4 * q);
  endfunction

  function automatic logic [8:0] cfga(input int q);
    return 9'(9'h180 + q);
  endfunction

  task automatic nib(input int q, output logic [3:0] n);
    logic [31:0] w;
    do_read(9'(9'h100 + q / 8), w);
    n = 4'((w >> (4 * (q % 8))) & 32'hF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rd_data after reset", rd_data, 32'h0);
    do_read(9'h100, v); check("R1/R5 stat word 0", v, 32'h3333_3333);
    do_read(9'h103, v); check("R1/R5 stat word 3", v, 32'h3333_3333);
    do_read(9'h104, v); check("R1 sticky word 0", v, 32'h0);
    do_read(9'h106, v); check("R1/R6 upper nearly-empty", v, 32'hFFFF_FFFF);
    do_read(9'h107, v); check("R1/R6 upper full", v, 32'h0);
    do_read(cfga(5), v); check("R1 default setup", v, 32'h8);
  endtask

  task automatic t_fifo();
    logic [31:0] v;
    do_write(win(3), 32'hA1);
    do_write(win(3), 32'hB2);
    do_write(win(3), 32'hC3);
    do_write(win(3) + 9'd1, 32'hDEAD);
    do_read(win(3) + 9'd1, v); check("R2 offset read zero", v, 32'h0);
    do_read(win(3), v); check("R2 pop first", v, 32'hA1);
    do_read(win(3), v); check("R2 pop second", v, 32'hB2);
    do_read(win(3), v); check("R2 pop third", v, 32'hC3);
    do_read(win(3), v); check("R2/R7 offset write ignored, empty pop", v, 32'h0);
    do_read(9'h104, v); check("R7 underflow q3", v, 32'h40);
  endtask

  task automatic t_watermark();
    logic [3:0] n;
    do_write(cfga(9), 32'h1208);
    for (int i = 0; i < 2; i++) do_write(win(9), 32'(i));
    nib(9, n); check("R4 ne at code2 count2", 32'(n), 32'h2);
    do_write(win(9), 32'h5);
    nib(9, n); check("R4 no flag count3", 32'(n), 32'h0);
    for (int i = 0; i < 4; i++) do_write(win(9), 32'(i));
    nib(9, n); check("R4/R5 nf free1", 32'(n), 32'h4);
    do_write(win(9), 32'h9);
    nib(9, n); check("R5 full and nf", 32'(n), 32'hC);
    do_write(cfga(10), 32'h0308);
    for (int i = 0; i < 4; i++) do_write(win(10), 32'(i));
    nib(10, n); check("R4 code3 means 4", 32'(n), 32'h2);
    do_write(win(10), 32'h7);
    nib(10, n); check("R4 code3 above", 32'(n), 32'h0);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    do_write(cfga(11), 32'h0000_7500);
    do_read(cfga(11), v); check("R3 len0 clamps, fields back", v, 32'h7508);
    do_write(cfga(11), 32'h20);
    do_read(cfga(11), v); check("R3 len above max clamps", v, 32'h8);
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    do_read(win(4), v); check("R7 empty pop zero", v, 32'h0);
    do_read(9'h104, v); check("R7 underflow q4", v, 32'h100);
    do_read(9'h104, v); check("R9 cleared by read", v, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    do_write(cfga(2), 32'h2);
    do_write(win(2), 32'h11);
    do_write(win(2), 32'h22);
    do_write(win(2), 32'h33);
    do_read(9'h104, v); check("R8 overflow q2", v, 32'h20);
    do_read(9'h104, v); check("R9 overflow cleared", v, 32'h0);
    do_read(win(2), v); check("R8 kept first", v, 32'h11);
    do_read(win(2), v); check("R8 kept second", v, 32'h22);
    do_write(win(2), 32'h44);
    do_write(win(2), 32'h55);
    do_both(win(2), 32'h66, 9'h104, v); check("R9 read during event", v, 32'h0);
    do_read(9'h104, v); check("R9 event beats clear", v, 32'h20);
    do_write(9'h104, 32'hFFFF_FFFF);
    do_read(9'h104, v); check("R11 sticky write ignored", v, 32'h0);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    do_write(cfga(40), 32'h0104);
    do_write(win(40), 32'h1);
    do_read(9'h106, v); check("R6 ne at count1", v, 32'hFFFF_FFFF);
    do_write(win(40), 32'h2);
    do_read(9'h106, v); check("R6 ne clears", v, 32'hFFFF_FEFF);
    do_write(win(40), 32'h3);
    do_read(9'h107, v); check("R6 not full at 3", v, 32'h0);
    do_write(win(40), 32'h4);
    do_read(9'h107, v); check("R6 full bit", v, 32'h100);
    do_read(win(40), v); check("R2 upper pop", v, 32'h1);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    logic [3:0]  n;
    do_write(cfga(6), 32'h2);
    do_write(win(6), 32'hE1);
    do_write(win(6), 32'hE2);
    do_both(win(6), 32'hE3, win(6), v); check("R10 pop while push full", v, 32'hE1);
    nib(6, n); check("R10 still full", 32'(n), 32'hC);
    do_read(win(6), v); check("R10 order 2", v, 32'hE2);
    do_read(win(6), v); check("R10 pushed word kept", v, 32'hE3);
    do_read(win(6), v); check("R10 now empty", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    do_write(9'h110, 32'h1234);
    do_read(9'h110, v); check("R11 unmapped read", v, 32'h0);
    do_write(9'h1C5, 32'h0003);
    do_read(9'h1C5, v); check("R11 unmapped high", v, 32'h0);
    do_read(cfga(5), v); check("R11 setup untouched", v, 32'h8);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fifo();
    t_watermark();
    t_clamp();
    t_underflow();
    t_overflow();
    t_upper();
    t_simul();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule